// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a pixel timing generator and the pins of a parallel RGB display bus. Each clock it takes one 24-bit pixel (8 bits each of red, green and blue, red in the top byte) together with active-high horizontal sync, vertical sync and data-enable. It drives a 24-line data bus, a display clock and three control pins. The pixel first passes through a channel reorder and then through one of several fixed packing layouts that place narrower colour fields onto the 24 lines. Pixel data and the three control signals are registered once, so they leave the block together.

A small synchronous register port holds a 17-bit control word. The word selects the reorder, the packing, and, for each control pin, its polarity, whether it changes on the rising or the falling clock edge, and whether it is forced to its inactive level. It also holds a display-clock inversion bit, an output-enable source bit and a global enable. Every offset other than zero reads a fixed identification constant. The pixel input carries no handshake and is never back-pressured: video timing is set upstream, so the block accepts one pixel on every clock edge and has no way to stall the source.

Top module: `rgb_bus_fmt`

## Requirements
- R1: The control word is at offset 0. It resets to 0, a write to offset 0 stores write-data bits 16:0, and reading offset 0 returns those 17 bits with bits 31:17 reading as 0.
- R2: A read from any nonzero offset returns 0x00647069, and a write to a nonzero offset leaves the control word unchanged.
- R3: Control bits 15:14 reorder the incoming channels into (first, second, third) before packing: 0 keeps (R,G,B), 1 gives (B,G,R), 2 gives (G,R,B), 3 gives (B,R,G).
- R4: Control bits 13:11 pick the packing. With f, s, t the reordered channels and the bus written MSB first: code 1 is 8 zeros, f[7:3], s[7:2], t[7:3]; code 2 is 3 zeros, f[7:3], 2 zeros, s[7:2], 3 zeros, t[7:3]; code 3 is 2 zeros, f[7:3], 3 zeros, s[7:2], 2 zeros, t[7:3], 1 zero.
- R5: Code 4 is 6 zeros, f[7:2], s[7:2], t[7:2]; code 5 is 2 zeros, f[7:2], 2 zeros, s[7:2], 2 zeros, t[7:2]; code 6 is f, s, t in full; codes 0 and 7 drive all data lines low.
- R6: A pixel and its sync and enable inputs sampled at one rising edge appear on the outputs after that edge, so data and control stay aligned with one cycle of latency.
- R7: Bit 10 inverts the display clock (not inverted, the display clock equals the block clock). Bits 9, 8 and 7 invert the hsync, vsync and output-enable pins.
- R8: Bits 6, 5 and 4 make the hsync, vsync and output-enable pins change half a cycle later, on the falling edge, instead of right after the rising edge.
- R9: Bits 3, 2 and 1 force the hsync, vsync and output-enable pins to their inactive level: low when the matching inversion bit is 0, high when it is 1.
- R10: Bit 0 is the global enable. While it is 0 the data lines, display clock and all three control pins are held low. When it goes from 0 to 1 the pipeline starts from a cleared state: data lines read 0 and control pins show their inactive level until the first pixel has been captured.
- R11: Bit 16 picks the output-enable source. When it is 1 the output-enable pin follows the data-enable input. When it is 0 the pin is held active whenever the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block and pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pix_rgb | input | 24 | Incoming pixel, red in bits 23:16 |
| pix_hs | input | 1 | Horizontal sync, active high |
| pix_vs | input | 1 | Vertical sync, active high |
| pix_de | input | 1 | Data enable, active high |
| bus_clk | output | 1 | Display clock |
| bus_data | output | 24 | Packed display data lines |
| bus_hs | output | 1 | Horizontal sync pin |
| bus_vs | output | 1 | Vertical sync pin |
| bus_oe | output | 1 | Output-enable pin |

## Verification
The hardest behaviour to reach from the ports is the half-cycle timing of the falling-edge mode and of the display clock. Both are set only by where, inside a clock period, the pins are sampled. The bench toggles a sync input and then samples one nanosecond after the rising edge, where the falling-edge pin must still show the old level, and again after the falling edge, where it must show the new one. The second awkward case is the enable restart. The bench keeps a nonzero pixel on the input, clears and then sets the enable, and checks that the bus reads zero for exactly the one cycle before the first new pixel is captured.

// File: rtl/rgbfmt_pkg.sv
package rgbfmt_pkg;

  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int NSIG   = 3;
  localparam int CTRL_W = 17;

  // control-pin indices inside the per-signal vectors
  localparam int SIG_OE = 0;
  localparam int SIG_VS = 1;
  localparam int SIG_HS = 2;

  typedef struct packed {
    logic [CH_W-1:0] c0;
    logic [CH_W-1:0] c1;
    logic [CH_W-1:0] c2;
  } pix_t;

  typedef enum logic [1:0] {
    ORD_KEEP = 2'd0,
    ORD_SWAP13 = 2'd1,
    ORD_SWAP12 = 2'd2,
    ORD_ROT = 2'd3
  } order_e;

  typedef enum logic [2:0] {
    PK_ZERO = 3'd0,
    PK_565_LO = 3'd1,
    PK_565_SP = 3'd2,
    PK_565_SH = 3'd3,
    PK_666_LO = 3'd4,
    PK_666_SP = 3'd5,
    PK_888 = 3'd6,
    PK_RSVD = 3'd7
  } pack_e;

  // field positions are fixed by the register layout
  typedef struct packed {
    logic            oe_follow;
    order_e          order;
    pack_e           pack;
    logic            clk_inv;
    logic [NSIG-1:0] inv;
    logic [NSIG-1:0] late;
    logic [NSIG-1:0] kill;
    logic            en;
  } ctrl_t;

endpackage

// File: rtl/rgbfmt_regs.sv
module rgbfmt_regs
  import rgbfmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output ctrl_t             ctrl
);

  localparam int PAD_W = 32 - CTRL_W;

  logic [CTRL_W-1:0] word_q;
  logic              hit_ctrl;
  logic              unused_wdata;

  assign hit_ctrl     = (addr == '0);
  assign unused_wdata = ^wdata[31:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr && hit_ctrl) begin
      word_q <= wdata[CTRL_W-1:0];
    end
  end

  assign ctrl  = ctrl_t'(word_q);
  assign rdata = hit_ctrl ? {{PAD_W{1'b0}}, word_q} : ID_VALUE;

endmodule

// File: rtl/rgbfmt_reorder.sv
module rgbfmt_reorder
  import rgbfmt_pkg::*;
(
  input  pix_t   px_in,
  input  order_e order,
  output pix_t   px_out
);

  always_comb begin
    unique case (order)
      ORD_KEEP:   px_out = px_in;
      ORD_SWAP13: px_out = '{c0: px_in.c2, c1: px_in.c1, c2: px_in.c0};
      ORD_SWAP12: px_out = '{c0: px_in.c1, c1: px_in.c0, c2: px_in.c2};
      ORD_ROT:    px_out = '{c0: px_in.c2, c1: px_in.c0, c2: px_in.c1};
      default:    px_out = px_in;
    endcase
  end

endmodule

// File: rtl/rgbfmt_pack.sv
module rgbfmt_pack
  import rgbfmt_pkg::*;
(
  input  pix_t             px,
  input  pack_e            pack,
  output logic [PIX_W-1:0] bus
);

  logic [4:0] f5, t5;
  logic [5:0] f6, s6, t6;

  assign f5 = px.c0[CH_W-1 -: 5];
  assign t5 = px.c2[CH_W-1 -: 5];
  assign f6 = px.c0[CH_W-1 -: 6];
  assign s6 = px.c1[CH_W-1 -: 6];
  assign t6 = px.c2[CH_W-1 -: 6];

  always_comb begin
    unique case (pack)
      PK_565_LO: bus = {8'b0, f5, s6, t5};
      PK_565_SP: bus = {3'b0, f5, 2'b0, s6, 3'b0, t5};
      PK_565_SH: bus = {2'b0, f5, 3'b0, s6, 2'b0, t5, 1'b0};
      PK_666_LO: bus = {6'b0, f6, s6, t6};
      PK_666_SP: bus = {2'b0, f6, 2'b0, s6, 2'b0, t6};
      PK_888:    bus = {px.c0, px.c1, px.c2};
      default:   bus = '0;
    endcase
  end

endmodule

// File: rtl/rgbfmt_sig.sv
module rgbfmt_sig (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic act_in,
  input  logic inv,
  input  logic late,
  input  logic kill,
  output logic pin
);

  logic rise_q;
  logic fall_q;
  logic level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rise_q <= 1'b0;
    else if (!en) rise_q <= 1'b0;
    else          rise_q <= act_in;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   fall_q <= 1'b0;
    else if (!en) fall_q <= 1'b0;
    else          fall_q <= rise_q;
  end

  assign level = late ? fall_q : rise_q;

  always_comb begin
    if (!en)       pin = 1'b0;
    else if (kill) pin = inv;
    else           pin = level ^ inv;
  end

endmodule

// File: rtl/rgb_bus_fmt.sv
module rgb_bus_fmt
  import rgbfmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PIX_W-1:0]  pix_rgb,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic              pix_de,
  output logic              bus_clk,
  output logic [PIX_W-1:0]  bus_data,
  output logic              bus_hs,
  output logic              bus_vs,
  output logic              bus_oe
);

  ctrl_t             ctrl;
  logic [CTRL_W-1:0] ctrl_q;
  pix_t              px_ord;
  logic [PIX_W-1:0]  packed_d;
  logic [PIX_W-1:0]  data_q;
  logic [NSIG-1:0]   sig_in;
  logic [NSIG-1:0]   sig_pin;

  rgbfmt_regs #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (reg_addr),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  assign ctrl_q = ctrl;

  rgbfmt_reorder u_reorder (
    .px_in  (pix_t'(pix_rgb)),
    .order  (ctrl.order),
    .px_out (px_ord)
  );

  rgbfmt_pack u_pack (
    .px   (px_ord),
    .pack (ctrl.pack),
    .bus  (packed_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (!ctrl.en) data_q <= '0;
    else               data_q <= packed_d;
  end

  assign bus_data = ctrl.en ? data_q : '0;
  assign bus_clk  = ctrl.en & (clk ^ ctrl.clk_inv);

  assign sig_in[SIG_HS] = pix_hs;
  assign sig_in[SIG_VS] = pix_vs;
  assign sig_in[SIG_OE] = ctrl.oe_follow ? pix_de : 1'b1;

  for (genvar i = 0; i < NSIG; i++) begin : g_sig
    rgbfmt_sig u_sig (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl.en),
      .act_in (sig_in[i]),
      .inv    (ctrl.inv[i]),
      .late   (ctrl.late[i]),
      .kill   (ctrl.kill[i]),
      .pin    (sig_pin[i])
    );
  end

  assign bus_hs = sig_pin[SIG_HS];
  assign bus_vs = sig_pin[SIG_VS];
  assign bus_oe = sig_pin[SIG_OE];

endmodule

// File: rtl/rgbfmt_chk.sv
module rgbfmt_chk #(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h0064_7069
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [23:0]       pix_rgb,
  input logic              pix_hs,
  input logic [23:0]       bus_data,
  input logic              bus_hs,
  input logic              bus_vs,
  input logic              bus_oe,
  input logic              bus_clk,
  input logic [16:0]       ctrl
);

  p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != '0) |-> (reg_rdata == ID_VALUE));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> (bus_data == '0 && !bus_hs && !bus_vs && !bus_oe && !bus_clk));

  p_full_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && $past(ctrl[0]) && $stable(ctrl) && ctrl[13:11] == 3'd6 && ctrl[15:14] == 2'd0)
      |-> (bus_data == $past(pix_rgb)));

  p_zero_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && $stable(ctrl) && (ctrl[13:11] == 3'd0 || ctrl[13:11] == 3'd7))
      |-> (bus_data == '0));

  p_hs_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[3]) |-> (bus_hs == ctrl[9]));

  p_hs_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && $past(ctrl[0]) && $stable(ctrl) && !ctrl[3])
      |-> (bus_hs == ($past(pix_hs) ^ ctrl[9])));

endmodule

bind rgb_bus_fmt rgbfmt_chk #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pix_rgb   (pix_rgb),
  .pix_hs    (pix_hs),
  .bus_data  (bus_data),
  .bus_hs    (bus_hs),
  .bus_vs    (bus_vs),
  .bus_oe    (bus_oe),
  .bus_clk   (bus_clk),
  .ctrl      (ctrl_q)
);

// File: tb/tb_rgb_bus_fmt.sv
module tb_rgb_bus_fmt;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] ID = 32'h0064_7069;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] pix_rgb = '0;
  logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic        bus_clk, bus_hs, bus_vs, bus_oe;
  logic [23:0] bus_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rgb_bus_fmt dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_rgb(pix_rgb),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de), .bus_clk(bus_clk),
    .bus_data(bus_data), .bus_hs(bus_hs), .bus_vs(bus_vs), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  // inv = {clk, hs, vs, oe}; late and kill = {hs, vs, oe}
  function automatic logic [31:0] mk(bit follow, int ord, int pk, logic [3:0] inv,
                                     logic [2:0] late, logic [2:0] kill, bit en);
    return {15'b0, follow, ord[1:0], pk[2:0], inv, late, kill, en};
  endfunction

  function automatic logic [23:0] exp_pack(int ord, int pk, logic [23:0] p);
    int r, g, b, f, s, t;
    r = (p >> 16) & 255; g = (p >> 8) & 255; b = p & 255;
    case (ord)
      0: begin f = r; s = g; t = b; end
      1: begin f = b; s = g; t = r; end
      2: begin f = g; s = r; t = b; end
      default: begin f = b; s = r; t = g; end
    endcase
    case (pk)
      1: return 24'((f / 8) * 2048 + (s / 4) * 32 + (t / 8));
      2: return 24'((f / 8) * 65536 + (s / 4) * 256 + (t / 8));
      3: return 24'((f / 8) * 131072 + (s / 4) * 256 + (t / 8) * 2);
      4: return 24'((f / 4) * 4096 + (s / 4) * 64 + (t / 4));
      5: return 24'((f / 4) * 65536 + (s / 4) * 256 + (t / 4));
      6: return 24'(f * 65536 + s * 256 + t);
      default: return 24'd0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] pats [4];
    pats[0] = 24'hFF_00_80; pats[1] = 24'h12_34_56;
    pats[2] = 24'hA5_5A_C3; pats[3] = 24'h0F_F0_7E;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    reg_addr = 4'h0; #0.5;
    check("R1 reset ctrl", reg_rdata, 32'h0);
    check("R10 reset data idle", {8'h0, bus_data}, 32'h0);
    check("R10 reset pins idle", {29'h0, bus_hs, bus_vs, bus_oe}, 32'h0);

    // R1 store and read back, upper bits masked
    wr_reg(4'h0, 32'hFFFF_FFFE);
    #0.5 check("R1 readback", reg_rdata, 32'h0001_FFFE);
    // R2 writes to other offsets ignored, ID returned
    wr_reg(4'h4, 32'h0000_0000);
    #0.5 check("R2 ctrl kept", reg_rdata, 32'h0001_FFFE);
    for (int a = 1; a < 16; a += 3) begin
      reg_addr = 4'(a); #0.5;
      check("R2 id read", reg_rdata, ID);
    end
    reg_addr = 4'h0;
    // R10 idle while disabled even with inversions set
    pix_hs = 1'b1; pix_rgb = 24'hFFFFFF; step();
    check("R10 disabled pins", {28'h0, bus_clk, bus_hs, bus_vs, bus_oe}, 32'h0);

    // R3 R4 R5 R6 sweep of orders, packings and pixels
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 8; k++) begin
        wr_reg(4'h0, mk(1, o, k, 4'h0, 3'h0, 3'h0, 1));
        for (int i = 0; i < 4; i++) begin
          pix_rgb = pats[i];
          step();
          check((k == 0 || k == 7) ? "R5 zero pack" :
                (k >= 4) ? "R5 wide pack R3" : "R4 narrow pack R3",
                {8'h0, bus_data}, {8'h0, exp_pack(o, k, pats[i])});
        end
      end
    end

    // R6 back-to-back pixels, each visible right after its capture edge
    wr_reg(4'h0, mk(1, 0, 6, 4'h0, 3'h0, 3'h0, 1));
    for (int i = 0; i < 6; i++) begin
      pix_rgb = 24'(i * 24'h111111 + 24'h010203);
      pix_hs = i[0];
      step();
      check("R6 data latency", {8'h0, bus_data}, {8'h0, 24'(i * 24'h111111 + 24'h010203)});
      check("R6 hs aligned", {31'h0, bus_hs}, {31'h0, i[0]});
    end

    // R7 R9 control pins: inversion and forcing for each signal
    for (int sg = 0; sg < 3; sg++) begin
      for (int iv = 0; iv < 2; iv++) begin
        for (int kl = 0; kl < 2; kl++) begin
          for (int v = 0; v < 2; v++) begin
            logic pin, expv;
            wr_reg(4'h0, mk(1, 0, 6, iv ? 4'(4 >> sg) : 4'h0, 3'h0,
                            kl ? 3'(4 >> sg) : 3'h0, 1));
            pix_hs = 1'b0; pix_vs = 1'b0; pix_de = 1'b0;
            if (sg == 0) pix_hs = v[0];
            else if (sg == 1) pix_vs = v[0];
            else pix_de = v[0];
            step();
            pin = (sg == 0) ? bus_hs : (sg == 1) ? bus_vs : bus_oe;
            expv = kl ? iv[0] : (v[0] ^ iv[0]);
            check(kl ? "R9 forced inactive" : "R7 polarity", {31'h0, pin}, {31'h0, expv});
          end
        end
      end
    end

    // R7 display clock polarity, sampled in high then low phase
    wr_reg(4'h0, mk(1, 0, 6, 4'h8, 3'h0, 3'h0, 1));
    step();
    check("R7 clk inverted high phase", {31'h0, bus_clk}, 32'h0);
    #2 check("R7 clk inverted low phase", {31'h0, bus_clk}, 32'h1);
    wr_reg(4'h0, mk(1, 0, 6, 4'h0, 3'h0, 3'h0, 1));
    check("R7 clk plain high phase", {31'h0, bus_clk}, 32'h1);

    // R8 falling-edge update for hs and vs, compared with rising-edge mode
    wr_reg(4'h0, mk(1, 0, 6, 4'h0, 3'b100, 3'h0, 1));
    pix_hs = 1'b0; step(); pix_hs = 1'b1; step();
    check("R8 hs late before fall", {31'h0, bus_hs}, 32'h0);
    #2 check("R8 hs late after fall", {31'h0, bus_hs}, 32'h1);
    wr_reg(4'h0, mk(1, 0, 6, 4'h0, 3'b010, 3'h0, 1));
    pix_vs = 1'b0; step(); pix_vs = 1'b1; step();
    check("R8 vs late before fall", {31'h0, bus_vs}, 32'h0);
    #2 check("R8 vs late after fall", {31'h0, bus_vs}, 32'h1);
    wr_reg(4'h0, mk(1, 0, 6, 4'h0, 3'b000, 3'h0, 1));
    pix_hs = 1'b0; step(); pix_hs = 1'b1; step();
    check("R8 hs early mode", {31'h0, bus_hs}, 32'h1);

    // R11 output-enable source
    wr_reg(4'h0, mk(0, 0, 6, 4'h0, 3'h0, 3'h0, 1));
    pix_de = 1'b0; step();
    check("R11 oe held active", {31'h0, bus_oe}, 32'h1);
    wr_reg(4'h0, mk(1, 0, 6, 4'h0, 3'h0, 3'h0, 1));
    pix_de = 1'b0; step();
    check("R11 oe follows de low", {31'h0, bus_oe}, 32'h0);
    pix_de = 1'b1; step();
    check("R11 oe follows de high", {31'h0, bus_oe}, 32'h1);

    // R10 disable then re-enable clears the pipeline
    pix_rgb = 24'hABCDEF; pix_hs = 1'b1;
    step();
    check("R10 running data", {8'h0, bus_data}, 32'h00AB_CDEF);
    wr_reg(4'h0, mk(1, 0, 6, 4'h4, 3'h0, 3'h0, 0));
    check("R10 idle data", {8'h0, bus_data}, 32'h0);
    check("R10 idle hs", {31'h0, bus_hs}, 32'h0);
    wr_reg(4'h0, mk(1, 0, 6, 4'h4, 3'h0, 3'h0, 1));
    check("R10 cleared data", {8'h0, bus_data}, 32'h0);
    check("R10 cleared hs inactive", {31'h0, bus_hs}, 32'h1);
    step();
    check("R10 first pixel after restart", {8'h0, bus_data}, 32'h00AB_CDEF);
    check("R10 first hs after restart", {31'h0, bus_hs}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule